// File: doc/BRIEF.md
# SDRAM Bring-up and Refresh Sequencer

This block sits on the controller side of a single-data-rate SDRAM. After a synchronous reset it waits for the device's power-up pause. It then issues one precharge that closes every bank, programs the mode register and runs a fixed number of auto refresh commands. Only after that does it report that initialization is complete. From then on it keeps a refresh credit counter that gains one credit per refresh interval. It spends those credits by issuing auto refresh whenever it owns the command bus.

A user port reaches the device through a request/grant pair. While the grant is high, the user's command, address, bank and mask inputs pass straight to the pins. The block takes the bus back when the user drops its request, which marks a burst boundary. It also takes the bus back when the number of postponed refreshes reaches its limit. Because the user may have left rows open, the first command after any grant period is a precharge of all banks, followed by the pending refreshes. Every interval is a parameter in clock cycles. The defaults are derived from nanosecond figures by rounding up, except the refresh interval, which rounds down.

Top module: `sdram_boot_refresh`

## Requirements
- R1: For PAUSE_CYC cycles after reset release, the pins carry NOP ({cs_n,ras_n,cas_n,we_n} = 0111), CKE is high, every DQM bit is high and init_done is low.
- R2: In cycle PAUSE_CYC after reset release, the block issues precharge (0010) with address bit 10 high.
- R3: Exactly TRP_CYC cycles after that precharge, the block issues mode register set (0000) with bank address 0. The address carries the mode word: burst code in bits 2:0, interleave flag in bit 3 and CAS latency in bits 6:4, with all higher bits 0.
- R4: The first auto refresh (0001) follows TMRD_CYC cycles after the mode register set. INIT_REFS refreshes are issued TRC_CYC cycles apart. init_done goes high in the cycle after the last of them and stays high until reset.
- R5: When the block drives the bus, a command other than NOP comes no sooner than TRC_CYC cycles after its last refresh and no sooner than TRP_CYC cycles after its last precharge.
- R6: After init_done rises, one refresh credit is added every REF_INT_CYC cycles. With an idle user port, each credit becomes an auto refresh in the cycle after it is added, provided the spacing of R5 allows.
- R7: usr_grant is never high before init_done. It rises one cycle after a cycle in which the block is free, no credit is pending and usr_req is high. While usr_grant is high, the pins equal the user inputs and CKE stays high.
- R8: usr_grant falls in the cycle after usr_req is seen low. The first block command after any grant period is a precharge with address bit 10 high, issued before any refresh.
- R9: While usr_grant is high and the pending count equals MAX_PENDING, usr_grant falls on the next cycle even if usr_req stays high.
- R10: When the block drives the bus and issues no command, the pins carry NOP with DQM high. CKE is high in every cycle.
- R11: Several pending credits are served back to back as refreshes TRC_CYC cycles apart, before the grant is given again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| usr_req | input | 1 | User asks for the command bus; low marks a burst boundary |
| usr_cmd | input | 4 | User command as {cs_n,ras_n,cas_n,we_n} |
| usr_addr | input | ADDR_W | User address |
| usr_ba | input | BA_W | User bank address |
| usr_dqm | input | DQM_W | User data mask |
| usr_grant | output | 1 | Pins follow the user inputs while high |
| init_done | output | 1 | Bring-up sequence has finished |
| sd_cke | output | 1 | Clock enable to the device |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_addr | output | ADDR_W | Address pins |
| sd_ba | output | BA_W | Bank address pins |
| sd_dqm | output | DQM_W | Data mask pins |

## Verification
On every cycle the assertions check the following:
- the quiet pause after reset;
- address bit 10 on each block precharge and the mode word on the mode register set;
- the precharge and refresh spacing of block commands;
- that a grant never comes before init_done, and that CKE stays high;
- that no refresh is issued while banks may still be open after a grant;
- that the grant is withdrawn once the pending count is full.

The bench scenarios show the rest: the exact cycle of each bring-up command, the number of refreshes issued over an idle window, the pass-through of user commands, release at a burst boundary, forced release followed by a chain of back-to-back refreshes, and a reset taken while the user is still asking for the bus.

// File: rtl/sdr_seq_pkg.sv
package sdr_seq_pkg;

    // Command pins packed as {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_MRS = 4'b0000,
        CMD_REF = 4'b0001,
        CMD_PRE = 4'b0010,
        CMD_NOP = 4'b0111
    } sdr_cmd_e;

    // Names the next command the sequencer owes
    typedef enum logic [1:0] {
        ST_BOOT_PALL,
        ST_BOOT_MRS,
        ST_BOOT_REF,
        ST_RUN
    } seq_state_e;

    typedef struct packed {
        sdr_cmd_e cmd;
        logic     all_banks;  // raise address bit 10
        logic     load_mode;  // place the mode word on the address
    } seq_drive_t;

    function automatic int ceil_cyc(input int ps, input int clk_ps);
        return (ps + clk_ps - 1) / clk_ps;
    endfunction

    function automatic int floor_cyc(input int ps, input int clk_ps);
        return ps / clk_ps;
    endfunction

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Mode word: burst code [2:0], interleave [3], CAS latency [6:4]
    function automatic logic [6:0] mode_bits(input int cas_lat, input int burst_code,
                                             input int interleave);
        int w;
        w = (cas_lat % 8) * 16 + ((interleave != 0) ? 8 : 0) + (burst_code % 8);
        return 7'(w);
    endfunction

endpackage

// File: rtl/sdr_countdown.sv
module sdr_countdown #(
    parameter int W    = 8,
    parameter int INIT = 0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] val,
    output logic         zero
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= W'(INIT);
        else if (load)
            cnt_q <= val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/sdr_refresh_credit.sv
module sdr_refresh_credit #(
    parameter int INTERVAL = 1953,
    parameter int MAX_PEND = 8,
    parameter int PW       = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          enable,
    input  logic          take,
    output logic [PW-1:0] pend
);
    localparam int IW = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;
    localparam logic [IW-1:0] RELOAD = IW'(INTERVAL - 1);
    localparam logic [PW-1:0] PMAX   = PW'(MAX_PEND);

    logic [IW-1:0] iv_q;
    logic          tick;

    assign tick = enable && (iv_q == '0);

    always_ff @(posedge clk) begin
        if (rst || !enable)
            iv_q <= RELOAD;
        else if (iv_q == '0)
            iv_q <= RELOAD;
        else
            iv_q <= iv_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= '0;
        end else begin
            unique case ({tick, take})
                2'b10:   if (pend != PMAX) pend <= pend + 1'b1;
                2'b01:   pend <= pend - 1'b1;
                default: pend <= pend;
            endcase
        end
    end
endmodule

// File: rtl/sdr_pin_mux.sv
module sdr_pin_mux
    import sdr_seq_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int BA_W   = 2,
    parameter int DQM_W  = 2,
    parameter logic [ADDR_W-1:0] MODE_WORD = '0
) (
    input  logic              grant,
    input  seq_drive_t        drv,
    input  logic [3:0]        usr_cmd,
    input  logic [ADDR_W-1:0] usr_addr,
    input  logic [BA_W-1:0]   usr_ba,
    input  logic [DQM_W-1:0]  usr_dqm,
    output logic              sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [ADDR_W-1:0] sd_addr,
    output logic [BA_W-1:0]   sd_ba,
    output logic [DQM_W-1:0]  sd_dqm
);
    localparam logic [ADDR_W-1:0] A10_MASK = ADDR_W'(1024);

    logic [ADDR_W-1:0] seq_addr;
    logic [3:0]        pins;

    always_comb begin
        if (drv.load_mode)
            seq_addr = MODE_WORD;
        else if (drv.all_banks)
            seq_addr = A10_MASK;
        else
            seq_addr = '0;
    end

    assign pins    = grant ? usr_cmd  : drv.cmd;
    assign sd_addr = grant ? usr_addr : seq_addr;
    assign sd_ba   = grant ? usr_ba   : '0;
    assign sd_dqm  = grant ? usr_dqm  : '1;
    assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = pins;
endmodule

// File: rtl/sdram_boot_refresh.sv
module sdram_boot_refresh
    import sdr_seq_pkg::*;
#(
    parameter int CLK_PS      = 8000,
    parameter int PAUSE_CYC   = ceil_cyc(200_000_000, CLK_PS),
    parameter int TRP_CYC     = ceil_cyc(18_000, CLK_PS),
    parameter int TRC_CYC     = ceil_cyc(60_000, CLK_PS),
    parameter int TMRD_CYC    = 2,
    parameter int REF_INT_CYC = floor_cyc(15_625_000, CLK_PS),
    parameter int INIT_REFS   = 8,
    parameter int MAX_PENDING = 8,
    parameter int ADDR_W      = 12,
    parameter int BA_W        = 2,
    parameter int DQM_W       = 2,
    parameter int CAS_LAT     = 3,
    parameter int BURST_CODE  = 2,
    parameter int INTERLEAVED = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              usr_req,
    input  logic [3:0]        usr_cmd,
    input  logic [ADDR_W-1:0] usr_addr,
    input  logic [BA_W-1:0]   usr_ba,
    input  logic [DQM_W-1:0]  usr_dqm,
    output logic              usr_grant,
    output logic              init_done,
    output logic              sd_cke,
    output logic              sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [ADDR_W-1:0] sd_addr,
    output logic [BA_W-1:0]   sd_ba,
    output logic [DQM_W-1:0]  sd_dqm
);
    localparam int TMAX = max_of(max_of(PAUSE_CYC, TRP_CYC), max_of(TRC_CYC, TMRD_CYC));
    localparam int TW   = $clog2(TMAX + 1);
    localparam int PW   = $clog2(MAX_PENDING + 1);
    localparam int RW   = $clog2(INIT_REFS + 1);
    localparam logic [TW-1:0] GAP_RP  = TW'(TRP_CYC - 1);
    localparam logic [TW-1:0] GAP_RC  = TW'(TRC_CYC - 1);
    localparam logic [TW-1:0] GAP_MRD = TW'(TMRD_CYC - 1);
    localparam logic [PW-1:0] PEND_FULL = PW'(MAX_PENDING);
    localparam logic [RW-1:0] LAST_REF  = RW'(INIT_REFS - 1);
    localparam logic [ADDR_W-1:0] MODE_WORD =
        {{(ADDR_W-7){1'b0}}, mode_bits(CAS_LAT, BURST_CODE, INTERLEAVED)};

    seq_state_e    st_q, st_d;
    logic [RW-1:0] refs_q, refs_d;
    logic          done_q, done_d;
    logic          grant_q, grant_d;
    logic          dirty_q, dirty_d;
    logic          tmr_load, tmr_zero;
    logic [TW-1:0] tmr_val;
    logic          take;
    logic [PW-1:0] pend_q;
    seq_drive_t    drv;

    sdr_countdown #(.W(TW), .INIT(PAUSE_CYC)) gap_tmr_i (
        .clk  (clk),
        .rst  (rst),
        .load (tmr_load),
        .val  (tmr_val),
        .zero (tmr_zero)
    );

    sdr_refresh_credit #(.INTERVAL(REF_INT_CYC), .MAX_PEND(MAX_PENDING), .PW(PW)) credit_i (
        .clk    (clk),
        .rst    (rst),
        .enable (done_q),
        .take   (take),
        .pend   (pend_q)
    );

    always_comb begin
        st_d     = st_q;
        refs_d   = refs_q;
        done_d   = done_q;
        grant_d  = grant_q;
        dirty_d  = dirty_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        take     = 1'b0;
        drv      = '{cmd: CMD_NOP, all_banks: 1'b0, load_mode: 1'b0};
        if (grant_q) begin
            // hand back at a burst boundary, or when refresh cannot wait longer
            if (!usr_req || pend_q == PEND_FULL)
                grant_d = 1'b0;
        end else if (tmr_zero) begin
            unique case (st_q)
                ST_BOOT_PALL: begin
                    drv.cmd       = CMD_PRE;
                    drv.all_banks = 1'b1;
                    tmr_load      = 1'b1;
                    tmr_val       = GAP_RP;
                    st_d          = ST_BOOT_MRS;
                end
                ST_BOOT_MRS: begin
                    drv.cmd       = CMD_MRS;
                    drv.load_mode = 1'b1;
                    tmr_load      = 1'b1;
                    tmr_val       = GAP_MRD;
                    refs_d        = '0;
                    st_d          = ST_BOOT_REF;
                end
                ST_BOOT_REF: begin
                    drv.cmd  = CMD_REF;
                    tmr_load = 1'b1;
                    tmr_val  = GAP_RC;
                    refs_d   = refs_q + 1'b1;
                    if (refs_q == LAST_REF) begin
                        st_d   = ST_RUN;
                        done_d = 1'b1;
                    end
                end
                ST_RUN: begin
                    if (pend_q != '0) begin
                        tmr_load = 1'b1;
                        if (dirty_q) begin
                            drv.cmd       = CMD_PRE;
                            drv.all_banks = 1'b1;
                            tmr_val       = GAP_RP;
                            dirty_d       = 1'b0;
                        end else begin
                            drv.cmd = CMD_REF;
                            tmr_val = GAP_RC;
                            take    = 1'b1;
                        end
                    end else if (usr_req) begin
                        grant_d = 1'b1;
                        dirty_d = 1'b1;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_BOOT_PALL;
            refs_q  <= '0;
            done_q  <= 1'b0;
            grant_q <= 1'b0;
            dirty_q <= 1'b0;
        end else begin
            st_q    <= st_d;
            refs_q  <= refs_d;
            done_q  <= done_d;
            grant_q <= grant_d;
            dirty_q <= dirty_d;
        end
    end

    sdr_pin_mux #(.ADDR_W(ADDR_W), .BA_W(BA_W), .DQM_W(DQM_W), .MODE_WORD(MODE_WORD)) pins_i (
        .grant    (grant_q),
        .drv      (drv),
        .usr_cmd  (usr_cmd),
        .usr_addr (usr_addr),
        .usr_ba   (usr_ba),
        .usr_dqm  (usr_dqm),
        .sd_cs_n  (sd_cs_n),
        .sd_ras_n (sd_ras_n),
        .sd_cas_n (sd_cas_n),
        .sd_we_n  (sd_we_n),
        .sd_addr  (sd_addr),
        .sd_ba    (sd_ba),
        .sd_dqm   (sd_dqm)
    );

    assign usr_grant = grant_q;
    assign init_done = done_q;
    assign sd_cke    = 1'b1;
endmodule

// File: rtl/sdr_seq_checker.sv
module sdr_seq_checker #(
    parameter int PAUSE_CYC   = 4,
    parameter int TRP_CYC     = 1,
    parameter int TRC_CYC     = 1,
    parameter int MAX_PENDING = 1,
    parameter int PW          = 1,
    parameter int ADDR_W      = 12,
    parameter int BA_W        = 2,
    parameter int DQM_W       = 2,
    parameter logic [ADDR_W-1:0] MODE_WORD = '0
) (
    input logic              clk,
    input logic              rst,
    input logic              sd_cke,
    input logic              sd_cs_n,
    input logic              sd_ras_n,
    input logic              sd_cas_n,
    input logic              sd_we_n,
    input logic [ADDR_W-1:0] sd_addr,
    input logic [BA_W-1:0]   sd_ba,
    input logic [DQM_W-1:0]  sd_dqm,
    input logic              usr_grant,
    input logic              init_done,
    input logic [PW-1:0]     pend
);
    logic [3:0] cmd;
    logic       own_cmd;
    int         cyc_q, since_pre_q, since_ref_q;
    logic       dirty_q;

    assign cmd     = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
    assign own_cmd = !usr_grant && (cmd != 4'b0111);

    always_ff @(posedge clk) begin
        if (rst) begin
            cyc_q       <= 0;
            since_pre_q <= TRP_CYC;
            since_ref_q <= TRC_CYC;
            dirty_q     <= 1'b0;
        end else begin
            if (cyc_q < PAUSE_CYC) cyc_q <= cyc_q + 1;
            if (!usr_grant && cmd == 4'b0010) since_pre_q <= 1;
            else if (since_pre_q < TRP_CYC) since_pre_q <= since_pre_q + 1;
            if (!usr_grant && cmd == 4'b0001) since_ref_q <= 1;
            else if (since_ref_q < TRC_CYC) since_ref_q <= since_ref_q + 1;
            if (usr_grant) dirty_q <= 1'b1;
            else if (cmd == 4'b0010) dirty_q <= 1'b0;
        end
    end

    p_pause_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        (cyc_q < PAUSE_CYC) |-> (cmd == 4'b0111 && sd_cke && (&sd_dqm) && !init_done));

    p_pall_a10_r2: assert property (@(posedge clk) disable iff (rst)
        (!usr_grant && cmd == 4'b0010) |-> sd_addr[10]);

    p_mode_word_r3: assert property (@(posedge clk) disable iff (rst)
        (!usr_grant && cmd == 4'b0000) |-> (sd_addr == MODE_WORD && sd_ba == '0));

    p_done_sticky_r4: assert property (@(posedge clk) disable iff (rst)
        init_done |=> init_done);

    p_rc_gap_r5: assert property (@(posedge clk) disable iff (rst)
        own_cmd |-> (since_ref_q >= TRC_CYC));

    p_rp_gap_r5: assert property (@(posedge clk) disable iff (rst)
        own_cmd |-> (since_pre_q >= TRP_CYC));

    p_grant_after_init_r7: assert property (@(posedge clk) disable iff (rst)
        usr_grant |-> init_done);

    p_close_before_ref_r8: assert property (@(posedge clk) disable iff (rst)
        (!usr_grant && cmd == 4'b0001) |-> !dirty_q);

    p_force_release_r9: assert property (@(posedge clk) disable iff (rst)
        (usr_grant && pend == PW'(MAX_PENDING)) |=> !usr_grant);

    p_cke_high_r10: assert property (@(posedge clk) disable iff (rst)
        sd_cke);
endmodule

bind sdram_boot_refresh sdr_seq_checker #(
    .PAUSE_CYC   (PAUSE_CYC),
    .TRP_CYC     (TRP_CYC),
    .TRC_CYC     (TRC_CYC),
    .MAX_PENDING (MAX_PENDING),
    .PW          (PW),
    .ADDR_W      (ADDR_W),
    .BA_W        (BA_W),
    .DQM_W       (DQM_W),
    .MODE_WORD   (MODE_WORD)
) chk_i (
    .clk       (clk),
    .rst       (rst),
    .sd_cke    (sd_cke),
    .sd_cs_n   (sd_cs_n),
    .sd_ras_n  (sd_ras_n),
    .sd_cas_n  (sd_cas_n),
    .sd_we_n   (sd_we_n),
    .sd_addr   (sd_addr),
    .sd_ba     (sd_ba),
    .sd_dqm    (sd_dqm),
    .usr_grant (usr_grant),
    .init_done (init_done),
    .pend      (pend_q)
);

// File: tb/sdram_boot_refresh_tb_top.sv
module sdram_boot_refresh_tb_top;
    localparam int PAUSE = 30;
    localparam int TRP   = 3;
    localparam int TRC   = 5;
    localparam int TMRD  = 2;
    localparam int RINT  = 40;
    localparam int NREF  = 8;
    localparam int PMAX  = 3;
    // R3: CAS latency 2, burst code 3, interleave 1 -> 0x02B
    localparam logic [11:0] MODE = 12'h02B;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        usr_req = 1'b0;
    logic [3:0]  usr_cmd = 4'b0111;
    logic [11:0] usr_addr = '0;
    logic [1:0]  usr_ba = '0;
    logic [1:0]  usr_dqm = '0;
    logic        usr_grant, init_done, sd_cke;
    logic        sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
    logic [11:0] sd_addr;
    logic [1:0]  sd_ba, sd_dqm;

    int checks = 0;
    int fails  = 0;
    int cycno  = 0;

    // behavioural reference state
    int m_wait, m_phase, m_refs, m_pend, m_iv;
    bit m_grant, m_dirty, m_done, m_forced;
    int since_done, run_refs, forced_seen;
    bit prev_grant_obs;

    always #4 clk = ~clk;

    sdram_boot_refresh #(
        .PAUSE_CYC(PAUSE), .TRP_CYC(TRP), .TRC_CYC(TRC), .TMRD_CYC(TMRD),
        .REF_INT_CYC(RINT), .INIT_REFS(NREF), .MAX_PENDING(PMAX),
        .ADDR_W(12), .BA_W(2), .DQM_W(2),
        .CAS_LAT(2), .BURST_CODE(3), .INTERLEAVED(1)
    ) dut_i (
        .clk(clk), .rst(rst), .usr_req(usr_req), .usr_cmd(usr_cmd),
        .usr_addr(usr_addr), .usr_ba(usr_ba), .usr_dqm(usr_dqm),
        .usr_grant(usr_grant), .init_done(init_done), .sd_cke(sd_cke),
        .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
        .sd_addr(sd_addr), .sd_ba(sd_ba), .sd_dqm(sd_dqm)
    );

    task automatic m_reset();
        m_wait = PAUSE; m_phase = 0; m_refs = 0; m_pend = 0; m_iv = RINT - 1;
        m_grant = 0; m_dirty = 0; m_done = 0; m_forced = 0;
        prev_grant_obs = 0;
    endtask

    // 0 none, 1 precharge-all, 2 mode set, 3 refresh
    function automatic int m_action();
        if (m_grant || m_wait != 0) return 0;
        case (m_phase)
            0: return 1;
            1: return 2;
            2: return 3;
            default: return (m_pend > 0) ? (m_dirty ? 1 : 3) : 0;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s cycle %0d %s: actual %h expected %h", req, cycno, what, act, exp);
        end
    endtask

    task automatic compare();
        int a;
        string tag;
        logic [3:0]  e_cmd;
        logic [11:0] e_addr;
        logic [1:0]  e_ba, e_dqm;
        logic [3:0]  o_cmd;
        a = m_action();
        if (m_grant) begin
            tag = "R7"; e_cmd = usr_cmd; e_addr = usr_addr; e_ba = usr_ba; e_dqm = usr_dqm;
        end else begin
            e_ba = 2'b00; e_dqm = 2'b11; e_addr = '0; e_cmd = 4'b0111;
            case (a)
                1: begin e_cmd = 4'b0010; e_addr = 12'h400; tag = (m_phase == 0) ? "R2" : "R8"; end
                2: begin e_cmd = 4'b0000; e_addr = MODE; tag = "R3"; end
                3: begin e_cmd = 4'b0001; tag = (m_phase == 2) ? "R4" : "R11"; end
                default: tag = (m_phase == 0) ? "R1" : ((m_wait > 0) ? "R5" : "R10");
            endcase
        end
        o_cmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
        check(o_cmd == e_cmd && sd_addr == e_addr && sd_ba == e_ba && sd_dqm == e_dqm && sd_cke,
              tag, "pins {cke,cmd,ba,dqm,addr}",
              {11'd0, sd_cke, o_cmd, sd_ba, sd_dqm, sd_addr},
              {11'd0, 1'b1, e_cmd, e_ba, e_dqm, e_addr});
        check(usr_grant == m_grant, m_forced ? "R9" : "R7", "usr_grant", usr_grant, m_grant);
        check(init_done == m_done, "R4", "init_done", init_done, m_done);
        if (init_done) begin
            if (!usr_grant && o_cmd == 4'b0001) run_refs++;
            since_done++;
        end
        if (prev_grant_obs && !usr_grant && usr_req) forced_seen++;
        prev_grant_obs = usr_grant;
    endtask

    task automatic m_advance();
        int  a;
        bit  tick, take, done_n;
        a = m_action();
        tick = m_done && (m_iv == 0);
        m_iv = (!m_done || m_iv == 0) ? RINT - 1 : m_iv - 1;
        take = 0; done_n = m_done; m_forced = 0;
        if (m_grant) begin
            if (!usr_req || m_pend == PMAX) begin
                m_forced = usr_req;
                m_grant = 0;
            end
            if (m_wait > 0) m_wait--;
        end else if (a == 1) begin
            m_wait = TRP - 1;
            if (m_phase == 0) m_phase = 1; else m_dirty = 0;
        end else if (a == 2) begin
            m_wait = TMRD - 1; m_phase = 2; m_refs = 0;
        end else if (a == 3) begin
            m_wait = TRC - 1;
            if (m_phase == 2) begin
                m_refs++;
                if (m_refs == NREF) begin m_phase = 3; done_n = 1; end
            end else take = 1;
        end else begin
            if (m_wait > 0) m_wait--;
            else if (m_phase == 3 && m_pend == 0 && usr_req) begin
                m_grant = 1; m_dirty = 1;
            end
        end
        if (tick && !take && m_pend < PMAX) m_pend++;
        else if (take && !tick) m_pend--;
        m_done = done_n;
    endtask

    task automatic cyc();
        #1;
        compare();
        @(posedge clk);
        m_advance();
        cycno++;
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        // R1: reset state is a quiet bus with no grant
        check({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0111 && sd_dqm == 2'b11,
              "R1", "cmd/dqm in reset", {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_dqm}, 6'b011111);
        check(!usr_grant && !init_done, "R1", "grant/done in reset", {usr_grant, init_done}, 2'b00);
        rst = 1'b0;
        m_reset();
        cycno = 0;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        #(8 * 200000);
        fails++; checks++;
        $display("FAIL R10 watchdog: actual still running expected finished");
        summary();
        $finish;
    end

    initial begin
        since_done = 0; run_refs = 0; forced_seen = 0;
        m_reset();
        @(negedge clk);
        do_reset();
        // boot sequence, then an idle window (R1-style pause, R2, R3, R4, R6)
        while (since_done < 130) cyc();
        // R6: refreshes in the first 130 cycles after init_done = floor(129/40)
        check(run_refs == 3, "R6", "refreshes in idle window", run_refs, 3);
        // R7: user traffic passes through
        usr_req = 1'b1; usr_addr = 12'h5A5; usr_ba = 2'd2; usr_dqm = 2'b01;
        for (int k = 0; k < 12; k++) begin
            usr_cmd = 4'(k + 3);
            usr_addr = usr_addr ^ 12'h0F3;
            cyc();
        end
        // R8: burst boundary releases the bus, precharge-all precedes refresh
        usr_req = 1'b0;
        repeat (60) cyc();
        // R9, R11: long hold forces release and a chain of refreshes
        usr_req = 1'b1; usr_cmd = 4'b0011;
        repeat (200) cyc();
        check(forced_seen >= 1, "R9", "forced releases seen", forced_seen, 1);
        usr_req = 1'b0;
        repeat (30) cyc();
        // R7: reset while requesting; no grant before init completes
        usr_req = 1'b1;
        do_reset();
        repeat (100) cyc();
        check(usr_grant == 1'b1, "R7", "grant after second bring-up", usr_grant, 1);
        summary();
        $finish;
    end
endmodule